// File: doc/BRIEF.md
# Triggered Fault Saboteur

This block sits in series with a data word and normally passes it straight through. A campaign is started by raising `arm`. From then on the block counts the cycles it has been armed. When the armed cycle index falls inside a programmed window and the trigger qualifiers agree, it corrupts the word for that cycle. The qualifiers are an address compare on an observed bus and an optional external event line. The corruption follows a programmed fault model: forcing masked bits low, forcing them high, inverting them, or presenting a value that arrived earlier on the same path.

Several bits can be faulted in the same cycle, which models multi-bit upsets. Changing the fault model, the mask or the trigger is only a change of configuration inputs; nothing structural moves. A random mode chooses both the injection cycles inside the window and the single target bit from a seeded pseudo-random sequence. A saturating count of faulted cycles and a window-closed flag let the surrounding campaign logic read the outcome.

Top module: `fault_saboteur`

## Requirements
- R1: While `arm` is low, `data_out` equals `data_in` in the same cycle, with no register in the path.
- R2: A faulted cycle produces `data_in & ~mask` for `cfg_mode`=0, `data_in | mask` for `cfg_mode`=1 and `data_in ^ mask` for `cfg_mode`=2, and any number of mask bits may be set at once.
- R3: The trigger fires only when `bus_addr` equals `cfg_addr` (if `cfg_addr_en` is 1) and `trig_ext` is high (if `cfg_ext_en` is 1), both sampled in the faulted cycle itself.
- R4: The armed cycle index is 0 in the first cycle with `arm` high and rises by one per clock. No fault is ever applied outside `cfg_win_lo` <= index <= `cfg_win_hi`.
- R5: With `cfg_persist`=0 and `cfg_random`=0, exactly one cycle is faulted per arming: the first cycle in the window where the trigger fires.
- R6: With `cfg_persist`=1 and `cfg_random`=0, every cycle is faulted from the first trigger cycle to the last window cycle, whether or not the trigger holds afterwards.
- R7: With `cfg_mode`=3, a faulted cycle outputs the `data_in` value from N cycles earlier, where N = `cfg_delay` for 1 to 15 and N = 1 when `cfg_delay` is 0.
- R8: With `cfg_random`=1, a 16-bit register is loaded with `cfg_seed` (1 if the seed is 0) while disarmed. During the armed cycle with index k it holds the seed advanced k times by s -> {s[14:0], s[15]^s[13]^s[12]^s[10]}. The trigger additionally needs bit 15 of that value. The mask becomes the single bit at position (value mod data width). Persistent mode faults every such cycle; one-shot mode faults only the first.
- R9: `fault_count` is cleared in the first armed cycle of a campaign and, one cycle after each faulted cycle, shows one more fault. It saturates at its maximum.
- R10: `done` rises in the cycle after the armed index reaches `cfg_win_hi` and stays high until the next rising edge of `arm` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Campaign enable; low means pure pass-through |
| trig_ext | input | 1 | External trigger event |
| bus_addr | input | ADDR_W | Observed address bus |
| data_in | input | DATA_W | Word entering the saboteur |
| cfg_mode | input | 2 | Fault model: 0 force-low, 1 force-high, 2 invert, 3 late data |
| cfg_persist | input | 1 | 1 keeps the fault until the window closes, 0 one cycle |
| cfg_random | input | 1 | Random injection points and target bit |
| cfg_mask | input | DATA_W | Bits to corrupt |
| cfg_seed | input | 16 | Pseudo-random seed |
| cfg_delay | input | DLY_W | Lateness in cycles for mode 3 |
| cfg_addr_en | input | 1 | Enable the address qualifier |
| cfg_addr | input | ADDR_W | Address to match |
| cfg_ext_en | input | 1 | Enable the external qualifier |
| cfg_win_lo | input | CYC_W | First armed cycle of the window |
| cfg_win_hi | input | CYC_W | Last armed cycle of the window |
| data_out | output | DATA_W | Word leaving the saboteur |
| fault_count | output | CNT_W | Faulted cycles in this campaign |
| done | output | 1 | Window has closed |

## Verification
The bench targets the window edges, for example an address hit at cycle 1000 against a window of width one. A design with an off-by-one index would fault at 999 or 1001, or not at all. It also places an address hit outside the window, which a design ignoring the window would corrupt. In one-shot mode, repeated trigger events after the first must leave the word untouched; a design that re-fires would push the count above one. In persistent mode, the trigger drops after its first hit, and a design that did not latch the fault would release the word early. Delay settings of 0 and 15 expose a wrong history tap or a missing clamp. In random mode, the bench's own generator sequence would reveal a wrong polynomial, seed handling or bit selection.

// File: rtl/fsab_pkg.sv
`timescale 1ns/1ps
package fsab_pkg;

    typedef enum logic [1:0] {
        FM_STUCK0 = 2'd0,
        FM_STUCK1 = 2'd1,
        FM_FLIP   = 2'd2,
        FM_DELAY  = 2'd3
    } fmode_e;

    localparam int RND_W = 16;

    // one step of the 16-bit generator, taps 16/14/13/11
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/fsab_trigger.sv
`timescale 1ns/1ps
module fsab_trigger
    import fsab_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig_ext,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cfg_addr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_ext_en,
    input  logic              cfg_random,
    input  logic [RND_W-1:0]  cfg_seed,
    input  logic [CYC_W-1:0]  cfg_win_lo,
    input  logic [CYC_W-1:0]  cfg_win_hi,
    output logic              in_win,
    output logic              win_closed,
    output logic              hit,
    output logic [RND_W-1:0]  rnd
);

    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [RND_W-1:0] lfsr;
    } trg_t;

    trg_t trg_d, trg_q;
    logic addr_ok, ext_ok, rnd_ok;

    always_comb begin
        trg_d = trg_q;
        if (arm) begin
            if (trg_q.cyc != CYC_MAX) trg_d.cyc = trg_q.cyc + 1'b1;
            trg_d.lfsr = rnd_step(trg_q.lfsr);
        end else begin
            trg_d.cyc  = '0;
            trg_d.lfsr = (cfg_seed == '0) ? RND_W'(1) : cfg_seed;
        end

        in_win     = arm && (trg_q.cyc >= cfg_win_lo) && (trg_q.cyc <= cfg_win_hi);
        win_closed = arm && (trg_q.cyc >= cfg_win_hi);
        addr_ok    = !cfg_addr_en || (bus_addr == cfg_addr);
        ext_ok     = !cfg_ext_en || trig_ext;
        rnd_ok     = !cfg_random || trg_q.lfsr[RND_W-1];
        hit        = in_win && addr_ok && ext_ok && rnd_ok;
        rnd        = trg_q.lfsr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trg_q.cyc  <= '0;
            trg_q.lfsr <= RND_W'(1);
        end else begin
            trg_q <= trg_d;
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trg_q.lfsr != '0);  // R8

endmodule

// File: rtl/fsab_history.sv
`timescale 1ns/1ps
module fsab_history #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 15,
    parameter int SEL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] late
);

    logic [DATA_W-1:0] hist_d [DEPTH];
    logic [DATA_W-1:0] hist_q [DEPTH];
    logic [SEL_W-1:0]  tap;

    always_comb begin
        hist_d[0] = data_in;
        for (int i = 1; i < DEPTH; i++) hist_d[i] = hist_q[i-1];
        tap  = (sel == '0) ? SEL_W'(1) : sel;
        late = hist_q[tap - SEL_W'(1)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tap != '0) && (int'(tap) <= DEPTH));  // R7

endmodule

// File: rtl/fsab_corrupt.sv
`timescale 1ns/1ps
module fsab_corrupt
    import fsab_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fmode_e            mode,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] late,
    output logic [DATA_W-1:0] data_f
);

    always_comb begin
        unique case (mode)
            FM_STUCK0: data_f = data_in & ~mask;
            FM_STUCK1: data_f = data_in | mask;
            FM_FLIP:   data_f = data_in ^ mask;
            default:   data_f = late;
        endcase
    end

endmodule

// File: rtl/fault_saboteur.sv
`timescale 1ns/1ps
module fault_saboteur
    import fsab_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int CYC_W   = 16,
    parameter int CNT_W   = 16,
    parameter int DLY_MAX = 15,
    parameter int DLY_W   = $clog2(DLY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig_ext,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_persist,
    input  logic              cfg_random,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [15:0]       cfg_seed,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              cfg_addr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_ext_en,
    input  logic [CYC_W-1:0]  cfg_win_lo,
    input  logic [CYC_W-1:0]  cfg_win_hi,
    output logic [DATA_W-1:0] data_out,
    output logic [CNT_W-1:0]  fault_count,
    output logic              done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             arm;
        logic             fired;
        logic [CNT_W-1:0] count;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              in_win, win_closed, hit, arm_rise, apply;
    logic [RND_W-1:0]  rnd;
    logic [RND_W-1:0]  rnd_pos;
    logic [DATA_W-1:0] mask_eff, late, data_f;
    logic [CNT_W-1:0]  cnt_base;

    fsab_trigger #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .trig_ext   (trig_ext),
        .bus_addr   (bus_addr),
        .cfg_addr_en(cfg_addr_en),
        .cfg_addr   (cfg_addr),
        .cfg_ext_en (cfg_ext_en),
        .cfg_random (cfg_random),
        .cfg_seed   (cfg_seed),
        .cfg_win_lo (cfg_win_lo),
        .cfg_win_hi (cfg_win_hi),
        .in_win     (in_win),
        .win_closed (win_closed),
        .hit        (hit),
        .rnd        (rnd)
    );

    fsab_history #(.DATA_W(DATA_W), .DEPTH(DLY_MAX), .SEL_W(DLY_W)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_in(data_in),
        .sel    (cfg_delay),
        .late   (late)
    );

    fsab_corrupt #(.DATA_W(DATA_W)) u_corrupt (
        .mode   (fmode_e'(cfg_mode)),
        .mask   (mask_eff),
        .data_in(data_in),
        .late   (late),
        .data_f (data_f)
    );

    always_comb begin
        rnd_pos  = rnd % RND_W'(DATA_W);
        mask_eff = cfg_random ? (DATA_W'(1) << rnd_pos) : cfg_mask;
        arm_rise = arm && !ctl_q.arm;

        if (!arm)
            apply = 1'b0;
        else if (cfg_persist)
            apply = cfg_random ? hit : (in_win && (hit || ctl_q.fired));
        else
            apply = hit && !ctl_q.fired;

        data_out = apply ? data_f : data_in;

        ctl_d       = ctl_q;
        ctl_d.arm   = arm;
        ctl_d.fired = arm && (ctl_q.fired || hit);
        cnt_base    = arm_rise ? '0 : ctl_q.count;
        ctl_d.count = (apply && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;
        ctl_d.done  = (arm_rise ? 1'b0 : ctl_q.done) || win_closed;

        fault_count = ctl_q.count;
        done        = ctl_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_BYPASS_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> (data_out == data_in));  // R1

    AST_FAULT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_out != data_in) |-> in_win);  // R4

    AST_RANDOM_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && cfg_random && cfg_mode != FM_DELAY) |-> ($countones(data_out ^ data_in) <= 1));  // R8

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arm) && cfg_win_hi != '0) |=> !done);  // R10

endmodule

// File: tb/fault_saboteur_test.sv
`timescale 1ns/1ps
module fault_saboteur_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        trig_ext = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] data_in = '0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_persist = 1'b0;
    logic        cfg_random = 1'b0;
    logic [31:0] cfg_mask = '0;
    logic [15:0] cfg_seed = '0;
    logic [3:0]  cfg_delay = '0;
    logic        cfg_addr_en = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic        cfg_ext_en = 1'b0;
    logic [15:0] cfg_win_lo = '0;
    logic [15:0] cfg_win_hi = '0;
    logic [31:0] data_out;
    logic [15:0] fault_count;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fault_saboteur uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_ext(trig_ext),
        .bus_addr(bus_addr), .data_in(data_in), .cfg_mode(cfg_mode),
        .cfg_persist(cfg_persist), .cfg_random(cfg_random), .cfg_mask(cfg_mask),
        .cfg_seed(cfg_seed), .cfg_delay(cfg_delay), .cfg_addr_en(cfg_addr_en),
        .cfg_addr(cfg_addr), .cfg_ext_en(cfg_ext_en), .cfg_win_lo(cfg_win_lo),
        .cfg_win_hi(cfg_win_hi), .data_out(data_out), .fault_count(fault_count),
        .done(done)
    );

    // {mode, mask, data_in, expected}
    localparam int NVEC = 8;
    localparam logic [97:0] VECS [NVEC] = '{
        {2'd0, 32'hFFFF0000, 32'h12345678, 32'h00005678},
        {2'd1, 32'h0000000F, 32'h12345670, 32'h1234567F},
        {2'd2, 32'h80000001, 32'h00000000, 32'h80000001},
        {2'd2, 32'h00FF00FF, 32'hA5A5A5A5, 32'hA55AA55A},
        {2'd0, 32'h00000000, 32'hDEADBEEF, 32'hDEADBEEF},
        {2'd1, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF},
        {2'd2, 32'h00000008, 32'h00000100, 32'h00000108},
        {2'd0, 32'hFFFFFFFF, 32'hCAFEF00D, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] gen_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // one edge with arm low, then arm high: caller is in armed cycle 0
    task automatic start_run();
        @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
        arm = 1'b1;
    endtask

    task automatic clear_cfg();
        trig_ext = 1'b0; bus_addr = '0; cfg_persist = 1'b0; cfg_random = 1'b0;
        cfg_addr_en = 1'b0; cfg_ext_en = 1'b0; cfg_delay = '0; cfg_mask = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] l;
        int fires;

        // reset state
        data_in = 32'h5A5A1234;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset bypass", data_out, 32'h5A5A1234);
        chk("R9 reset count", {16'h0, fault_count}, 32'h0);
        chk("R10 reset done", {31'h0, done}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 vector table, wide window, persistent, no qualifiers
        clear_cfg();
        cfg_persist = 1'b1;
        cfg_win_lo = 16'd0;
        cfg_win_hi = 16'hFFFF;
        start_run();
        for (int v = 0; v < NVEC; v++) begin
            cfg_mode = VECS[v][97:96];
            cfg_mask = VECS[v][95:64];
            data_in  = VECS[v][63:32];
            #1;
            chk("R2 fault model vector", data_out, VECS[v][31:0]);
            @(negedge clk);
        end
        // R1 disarmed: mask all ones must not matter
        arm = 1'b0;
        cfg_mode = 2'd1; cfg_mask = 32'hFFFFFFFF; data_in = 32'h00C0FFEE;
        #1;
        chk("R1 disarmed bypass", data_out, 32'h00C0FFEE);

        // R3/R4/R5 address 0x100 at cycle 1000 flips bit 3
        clear_cfg();
        cfg_mode = 2'd2; cfg_mask = 32'h8;
        cfg_addr_en = 1'b1; cfg_addr = 16'h0100;
        cfg_win_lo = 16'd1000; cfg_win_hi = 16'd1000;
        start_run();
        for (int k = 0; k <= 1002; k++) begin
            bus_addr = (k == 500 || k == 1000 || k == 1001) ? 16'h0100 : 16'h00FF;
            data_in = 32'(k);
            #1;
            if (k == 500) chk("R4 hit outside window", data_out, 32'(k));
            if (k == 999 || k == 1001) chk("R4 window edge", data_out, 32'(k));
            if (k == 1000) chk("R3 address and cycle hit", data_out, 32'(k) ^ 32'h8);
            if (k == 1002) begin
                chk("R9 single count", {16'h0, fault_count}, 32'd1);
                chk("R10 done after window", {31'h0, done}, 32'd1);
            end
            @(negedge clk);
        end

        // R5 one-shot with external trigger repeated
        clear_cfg();
        cfg_mode = 2'd2; cfg_mask = 32'h1; cfg_ext_en = 1'b1;
        cfg_win_lo = 16'd3; cfg_win_hi = 16'd8;
        start_run();
        for (int k = 0; k <= 9; k++) begin
            trig_ext = (k == 2 || k == 4 || k == 6);
            data_in = 32'hF0;
            #1;
            if (k == 4) chk("R5 first external hit", data_out, 32'hF1);
            else if (k <= 8) chk("R5 no refire / R3 ext gate", data_out, 32'hF0);
            if (k == 8) chk("R10 done not yet", {31'h0, done}, 32'd0);
            if (k == 9) begin
                chk("R5 one fault per arming", {16'h0, fault_count}, 32'd1);
                chk("R10 done set", {31'h0, done}, 32'd1);
            end
            @(negedge clk);
        end

        // R6 persistent after single address hit
        clear_cfg();
        cfg_mode = 2'd1; cfg_mask = 32'h0000FF00; cfg_persist = 1'b1;
        cfg_addr_en = 1'b1; cfg_addr = 16'h0100;
        cfg_win_lo = 16'd3; cfg_win_hi = 16'd8;
        start_run();
        for (int k = 0; k <= 10; k++) begin
            bus_addr = (k == 5) ? 16'h0100 : 16'h0000;
            data_in = 32'h0;
            #1;
            chk("R6 persistent span", data_out, (k >= 5 && k <= 8) ? 32'h0000FF00 : 32'h0);
            if (k == 10) chk("R9 persistent count", {16'h0, fault_count}, 32'd4);
            @(negedge clk);
        end
        // re-arm clears count and done
        start_run();
        @(negedge clk);
        #1;
        chk("R10 done cleared on re-arm", {31'h0, done}, 32'd0);
        chk("R9 count cleared on re-arm", {16'h0, fault_count}, 32'd0);

        // R7 delay 3, persistent window 5..9
        clear_cfg();
        cfg_mode = 2'd3; cfg_delay = 4'd3; cfg_persist = 1'b1;
        cfg_win_lo = 16'd5; cfg_win_hi = 16'd9;
        start_run();
        for (int k = 0; k <= 10; k++) begin
            data_in = 32'h1000 + 32'(k);
            #1;
            chk("R7 delay 3", data_out, (k >= 5 && k <= 9) ? 32'h1000 + 32'(k - 3) : 32'h1000 + 32'(k));
            @(negedge clk);
        end
        // delay 0 acts as 1
        cfg_delay = 4'd0; cfg_persist = 1'b0;
        cfg_win_lo = 16'd2; cfg_win_hi = 16'd2;
        start_run();
        for (int k = 0; k <= 3; k++) begin
            data_in = 32'h2000 + 32'(k);
            #1;
            if (k == 2) chk("R7 delay 0 means 1", data_out, 32'h2001);
            @(negedge clk);
        end
        // delay 15
        cfg_delay = 4'd15;
        cfg_win_lo = 16'd20; cfg_win_hi = 16'd20;
        start_run();
        for (int k = 0; k <= 21; k++) begin
            data_in = 32'h3000 + 32'(k);
            #1;
            if (k >= 19) chk("R7 delay 15", data_out, (k == 20) ? 32'h3005 : 32'h3000 + 32'(k));
            @(negedge clk);
        end

        // R8 random points and bit
        clear_cfg();
        cfg_mode = 2'd2; cfg_random = 1'b1; cfg_persist = 1'b1;
        cfg_mask = 32'hFFFFFFFF; cfg_seed = 16'hACE1;
        cfg_win_lo = 16'd0; cfg_win_hi = 16'd63;
        start_run();
        l = 16'hACE1;
        fires = 0;
        for (int k = 0; k <= 64; k++) begin
            data_in = 32'h0;
            #1;
            if (k <= 63) begin
                chk("R8 random injection", data_out, l[15] ? (32'h1 << l[4:0]) : 32'h0);
                if (l[15]) fires++;
                l = gen_step(l);
            end else begin
                chk("R8 random count", {16'h0, fault_count}, 32'(fires));
                chk("R4 random after window", data_out, 32'h0);
            end
            @(negedge clk);
        end
        // seed 0 loads 1: first armed cycles have bit 15 clear until shifted up
        cfg_seed = 16'h0; cfg_persist = 1'b0;
        start_run();
        l = 16'h0001;
        for (int k = 0; k <= 20; k++) begin
            #1;
            chk("R8 seed zero", data_out, (l[15] && k == 15) ? (32'h1 << l[4:0]) : 32'h0);
            l = gen_step(l);
            @(negedge clk);
        end

        arm = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

endmodule